// File: doc/BRIEF.md
# Stop-Mode Clock Loss Supervisor

This block decides how the chip reacts when the oscillator clock disappears while it sits in its pseudo-stop low-power state. A clock-monitor failure input, a per-oscillator-cycle tick and three configuration bits choose one of three responses. The loss can be ignored. The chip can be sent to reset at once. Or the chip can stay asleep on a PLL-driven self-clock while a quality check counts oscillator cycles.

In the self-clock fallback the block turns on the regulator and the PLL and raises a sticky interrupt flag. It then restarts its quality counter after every monitor failure. Once enough clean oscillator cycles have been counted, it shuts things down in order: self-clock first, then the PLL, then the regulator, and the chip stays in pseudo-stop. A wakeup or an external reset ends pseudo-stop. The system clock then comes from the oscillator if the check has passed, and otherwise from the PLL, with checks going on until the oscillator proves good. The analog monitor, PLL, regulator and clock mux are outside this block and appear only as signals.

Top module: `stop_clk_supervisor`

## Requirements
- R1: During and right after reset the block is in the run state: `vreg_en`=1, `pll_en`=0, `scm_active`=0, `sysclk_pll`=0, `scm_flag`=0, and `cm_rst`, `stop_exit` and `seq_reset` are all 0.
- R11: In the run state, a `stop_req` high on one clock edge puts the block in pseudo-stop. From the next cycle `vreg_en`=0 and `pll_en`=0.
- R2: In pseudo-stop with `cfg_mon_en`=0, `cm_fail` has no effect. The block stays in pseudo-stop (`vreg_en`=0), and `scm_active`, `cm_rst` and `scm_flag` stay 0.
- R3: In pseudo-stop with `cfg_mon_en`=1 and `cfg_scm_en`=0, a `cm_fail` cycle makes `cm_rst` high for exactly one cycle after the next edge. The block returns to the run state (`vreg_en`=1) without entering self-clock mode and without setting the flag.
- R4: In pseudo-stop with `cfg_mon_en`=1 and `cfg_scm_en`=1, a `cm_fail` cycle makes `scm_active`, `pll_en`, `vreg_en`, `sysclk_pll` and `scm_flag` all equal 1 after the next edge. No exit strobe is given.
- R5: While in self-clock mode, the quality check passes on the QC_CYCLES-th (default 4096) consecutive cycle that has `osc_tick`=1 and `cm_fail`=0. Any `cm_fail` cycle clears the count, and the checks repeat without limit while the failure lasts.
- R6: When the check passes in pseudo-stop, `scm_active` drops after the next edge while `pll_en` and `vreg_en` stay 1. `pll_en` drops one cycle later, `vreg_en` drops one cycle after that, and pseudo-stop is kept (`stop_exit`=0).
- R7: A `wakeup` in pseudo-stop with no self-clock active gives a one-cycle `stop_exit` pulse after the next edge, with `sysclk_pll`=0 and `vreg_en`=1.
- R8: A `wakeup` while in self-clock pseudo-stop gives a `stop_exit` pulse with `sysclk_pll`=1 and `pll_en`=1. Quality checks continue. When one passes, `scm_active`, `pll_en` and `sysclk_pll` drop to 0 together.
- R9: `ext_rst` gives a one-cycle `seq_reset` pulse. In pseudo-stop it also pulses `stop_exit`, with `sysclk_pll`=1 if self-clock is active and 0 otherwise.
- R10: `scm_flag` is sticky and is cleared by `flag_clr`=1 (write 1 to clear). A set in the same cycle wins over a clear. `scm_irq` equals `scm_flag` AND `cfg_irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One oscillator cycle observed this clock |
| cm_fail | input | 1 | Clock monitor reports oscillator failure |
| stop_req | input | 1 | Enter pseudo-stop (run state only) |
| wakeup | input | 1 | Wakeup interrupt |
| ext_rst | input | 1 | External reset request |
| cfg_mon_en | input | 1 | Clock monitor enable |
| cfg_scm_en | input | 1 | Self-clock fallback enable |
| cfg_irq_en | input | 1 | Self-clock interrupt enable |
| flag_clr | input | 1 | Write-1-to-clear for the flag |
| vreg_en | output | 1 | Regulator enable |
| pll_en | output | 1 | PLL enable |
| scm_active | output | 1 | Self-clock mode active |
| cm_rst | output | 1 | One-cycle clock-monitor reset request |
| scm_flag | output | 1 | Sticky self-clock flag |
| scm_irq | output | 1 | Self-clock interrupt request |
| sysclk_pll | output | 1 | System clock source: 1 = PLL, 0 = oscillator |
| stop_exit | output | 1 | One-cycle pseudo-stop exit strobe |
| seq_reset | output | 1 | One-cycle reset-sequence start |

## Verification
The assertions assume that `cm_fail`, `wakeup` and `ext_rst` are synchronous to `clk`, and that the configuration bits do not change in the cycle in which a loss is being acted on. The stimulus drives every input one time unit after a rising edge and changes configuration only while the block is in the run state. It never raises a loss and an exit request in the same cycle. Because `osc_tick` is held high, the quality-check windows have an exact length of 4096 cycles.

// File: rtl/stop_clk_sup_pkg.sv
package stop_clk_sup_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_STOP,
        ST_SCM_STOP,
        ST_DN_SCM,
        ST_DN_PLL,
        ST_SCM_RUN
    } sup_state_e;

    typedef struct packed {
        logic mon_en;
        logic scm_en;
    } loss_cfg_t;

    typedef struct packed {
        logic vreg_en;
        logic pll_en;
        logic scm_active;
        logic sel_pll;
    } pwr_ctl_t;

    function automatic pwr_ctl_t decode_pwr(sup_state_e s);
        pwr_ctl_t p;
        case (s)
            ST_RUN:      p = '{vreg_en: 1'b1, pll_en: 1'b0, scm_active: 1'b0, sel_pll: 1'b0};
            ST_STOP:     p = '{vreg_en: 1'b0, pll_en: 1'b0, scm_active: 1'b0, sel_pll: 1'b0};
            ST_SCM_STOP: p = '{vreg_en: 1'b1, pll_en: 1'b1, scm_active: 1'b1, sel_pll: 1'b1};
            ST_DN_SCM:   p = '{vreg_en: 1'b1, pll_en: 1'b1, scm_active: 1'b0, sel_pll: 1'b0};
            ST_DN_PLL:   p = '{vreg_en: 1'b1, pll_en: 1'b0, scm_active: 1'b0, sel_pll: 1'b0};
            ST_SCM_RUN:  p = '{vreg_en: 1'b1, pll_en: 1'b1, scm_active: 1'b1, sel_pll: 1'b1};
            default:     p = '{vreg_en: 1'b1, pll_en: 1'b0, scm_active: 1'b0, sel_pll: 1'b0};
        endcase
        return p;
    endfunction

    function automatic logic is_scm(sup_state_e s);
        return (s == ST_SCM_STOP) || (s == ST_SCM_RUN);
    endfunction

endpackage

// File: rtl/qual_counter.sv
module qual_counter #(
    parameter int QC_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic osc_tick,
    input  logic cm_fail,
    output logic pass
);
    localparam int CNT_W = (QC_CYCLES > 1) ? $clog2(QC_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(QC_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign pass = run && osc_tick && !cm_fail && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || cm_fail || pass) begin
            cnt <= '0;
        end else if (osc_tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_CLEARED_BY_FAIL: assert property (@(posedge clk) disable iff (rst)
        (run && cm_fail) |=> (cnt == '0)); // R5
    AST_NO_PASS_DURING_FAIL: assert property (@(posedge clk) disable iff (rst)
        cm_fail |-> !pass); // R5

endmodule

// File: rtl/scm_flag_reg.sv
module scm_flag_reg (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set_i) begin
            flag <= 1'b1;
        end else if (clr_i) begin
            flag <= 1'b0;
        end
    end

    assign irq = flag & irq_en;

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag); // R10
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag); // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_i) |=> flag); // R10

endmodule

// File: rtl/loss_ctrl_fsm.sv
module loss_ctrl_fsm
    import stop_clk_sup_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  loss_cfg_t cfg,
    input  logic      cm_fail,
    input  logic      stop_req,
    input  logic      wakeup,
    input  logic      ext_rst,
    input  logic      qc_pass,
    output pwr_ctl_t  pwr,
    output logic      qc_run,
    output logic      flag_set,
    output logic      cm_rst,
    output logic      stop_exit,
    output logic      seq_reset
);
    sup_state_e state, state_nx;
    logic       exit_req, loss_seen, rst_nx, exit_nx;

    assign exit_req  = wakeup || ext_rst;
    assign loss_seen = cfg.mon_en && cm_fail;
    assign pwr       = decode_pwr(state);
    assign qc_run    = is_scm(state);
    assign flag_set  = (state == ST_STOP) && loss_seen && cfg.scm_en;

    always_comb begin
        state_nx = state;
        rst_nx   = 1'b0;
        exit_nx  = 1'b0;
        case (state)
            ST_RUN: begin
                if (stop_req) state_nx = ST_STOP;
            end
            ST_STOP: begin
                if (loss_seen) begin
                    if (cfg.scm_en) begin
                        state_nx = ST_SCM_STOP;
                    end else begin
                        state_nx = ST_RUN;
                        rst_nx   = 1'b1;
                    end
                end else if (exit_req) begin
                    state_nx = ST_RUN;
                    exit_nx  = 1'b1;
                end
            end
            ST_SCM_STOP: begin
                if (exit_req) begin
                    state_nx = qc_pass ? ST_RUN : ST_SCM_RUN;
                    exit_nx  = 1'b1;
                end else if (qc_pass) begin
                    state_nx = ST_DN_SCM;
                end
            end
            ST_DN_SCM: begin
                if (exit_req) begin
                    state_nx = ST_RUN;
                    exit_nx  = 1'b1;
                end else begin
                    state_nx = ST_DN_PLL;
                end
            end
            ST_DN_PLL: begin
                if (exit_req) begin
                    state_nx = ST_RUN;
                    exit_nx  = 1'b1;
                end else begin
                    state_nx = ST_STOP;
                end
            end
            ST_SCM_RUN: begin
                if (qc_pass) state_nx = ST_RUN;
            end
            default: state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_RUN;
            cm_rst    <= 1'b0;
            stop_exit <= 1'b0;
            seq_reset <= 1'b0;
        end else begin
            state     <= state_nx;
            cm_rst    <= rst_nx;
            stop_exit <= exit_nx;
            seq_reset <= ext_rst;
        end
    end

    AST_CMRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cm_rst |=> !cm_rst); // R3
    AST_CMRST_NO_SCM: assert property (@(posedge clk) disable iff (rst)
        cm_rst |-> !pwr.scm_active); // R3
    AST_SCM_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr.scm_active) |-> $past(cfg.mon_en && cfg.scm_en)); // R4
    AST_SCM_POWERED: assert property (@(posedge clk) disable iff (rst)
        pwr.scm_active |-> (pwr.pll_en && pwr.vreg_en && pwr.sel_pll)); // R4
    AST_MON_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!cfg.mon_en && state == ST_STOP) |=> (!pwr.scm_active && !cm_rst)); // R2
    AST_PLL_OFF_BEFORE_VREG: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr.vreg_en) |-> (!pwr.pll_en && !$past(pwr.pll_en))); // R6
    AST_EXIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        stop_exit |=> !stop_exit); // R7

endmodule

// File: rtl/stop_clk_supervisor.sv
module stop_clk_supervisor
    import stop_clk_sup_pkg::*;
#(
    parameter int QC_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_tick,
    input  logic cm_fail,
    input  logic stop_req,
    input  logic wakeup,
    input  logic ext_rst,
    input  logic cfg_mon_en,
    input  logic cfg_scm_en,
    input  logic cfg_irq_en,
    input  logic flag_clr,
    output logic vreg_en,
    output logic pll_en,
    output logic scm_active,
    output logic cm_rst,
    output logic scm_flag,
    output logic scm_irq,
    output logic sysclk_pll,
    output logic stop_exit,
    output logic seq_reset
);
    loss_cfg_t cfg;
    pwr_ctl_t  pwr;
    logic      qc_run, qc_pass, flag_set;

    assign cfg = '{mon_en: cfg_mon_en, scm_en: cfg_scm_en};

    qual_counter #(.QC_CYCLES(QC_CYCLES)) u_qc (
        .clk      (clk),
        .rst      (rst),
        .run      (qc_run),
        .osc_tick (osc_tick),
        .cm_fail  (cm_fail),
        .pass     (qc_pass)
    );

    loss_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .cm_fail   (cm_fail),
        .stop_req  (stop_req),
        .wakeup    (wakeup),
        .ext_rst   (ext_rst),
        .qc_pass   (qc_pass),
        .pwr       (pwr),
        .qc_run    (qc_run),
        .flag_set  (flag_set),
        .cm_rst    (cm_rst),
        .stop_exit (stop_exit),
        .seq_reset (seq_reset)
    );

    scm_flag_reg u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (flag_set),
        .clr_i  (flag_clr),
        .irq_en (cfg_irq_en),
        .flag   (scm_flag),
        .irq    (scm_irq)
    );

    assign vreg_en    = pwr.vreg_en;
    assign pll_en     = pwr.pll_en;
    assign scm_active = pwr.scm_active;
    assign sysclk_pll = pwr.sel_pll;

    AST_SEQRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (seq_reset && !$past(ext_rst, 2)) |=> !seq_reset || $past(ext_rst)); // R9

endmodule

// File: tb/sim_stop_clk_supervisor.sv
`timescale 1ns/1ps
module sim_stop_clk_supervisor;
    logic clk = 1'b0;
    logic rst, osc_tick, cm_fail, stop_req, wakeup, ext_rst;
    logic cfg_mon_en, cfg_scm_en, cfg_irq_en, flag_clr;
    logic vreg_en, pll_en, scm_active, cm_rst, scm_flag, scm_irq;
    logic sysclk_pll, stop_exit, seq_reset;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    stop_clk_supervisor u0 (.*);

    // [5]mon [4]scm [3]irq_en | expected [2]cm_rst [1]scm_active [0]scm_irq
    localparam logic [5:0] VEC [5] = '{
        6'b001_000, 6'b011_000, 6'b101_100, 6'b111_011, 6'b110_010
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; osc_tick = 1'b1; cm_fail = 1'b0; stop_req = 1'b0;
        wakeup = 1'b0; ext_rst = 1'b0; flag_clr = 1'b0;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic enter_stop();
        stop_req = 1'b1; step(); stop_req = 1'b0;
        chk("R11 vreg_en off in stop", vreg_en, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end

    initial begin
        cfg_mon_en = 1'b1; cfg_scm_en = 1'b1; cfg_irq_en = 1'b1;
        do_reset();
        chk("R1 vreg_en", vreg_en, 1'b1);
        chk("R1 pll_en", pll_en, 1'b0);
        chk("R1 scm_active", scm_active, 1'b0);
        chk("R1 sysclk_pll", sysclk_pll, 1'b0);
        chk("R1 scm_flag", scm_flag, 1'b0);
        chk("R1 pulses", cm_rst | stop_exit | seq_reset, 1'b0);

        // Table: loss response per configuration (R2 R3 R4 R10)
        for (int i = 0; i < 5; i++) begin
            do_reset();
            cfg_mon_en = VEC[i][5]; cfg_scm_en = VEC[i][4]; cfg_irq_en = VEC[i][3];
            enter_stop();
            cm_fail = 1'b1; step(); cm_fail = 1'b0;
            chk("R3 cm_rst response", cm_rst, VEC[i][2]);
            chk("R4 scm_active response", scm_active, VEC[i][1]);
            chk("R10 scm_irq response", scm_irq, VEC[i][0]);
            chk("R4 no exit strobe", stop_exit, 1'b0);
            if (!VEC[i][5]) begin
                chk("R2 stays in stop", vreg_en, 1'b0);
                chk("R2 flag untouched", scm_flag, 1'b0);
            end
            if (VEC[i][2]) begin
                chk("R3 back to run", vreg_en, 1'b1);
                step();
                chk("R3 cm_rst one cycle", cm_rst, 1'b0);
                chk("R3 no flag", scm_flag, 1'b0);
            end
            if (VEC[i][1]) begin
                chk("R4 pll_en", pll_en, 1'b1);
                chk("R4 sysclk_pll", sysclk_pll, 1'b1);
                chk("R4 flag set", scm_flag, 1'b1);
            end
        end

        // Recovery in pseudo-stop with a counter restart (R5 R6 R10 R7)
        cfg_mon_en = 1'b1; cfg_scm_en = 1'b1; cfg_irq_en = 1'b1;
        do_reset();
        enter_stop();
        cm_fail = 1'b1; step();
        repeat (10) step();
        cm_fail = 1'b0;
        repeat (2000) step();
        cm_fail = 1'b1; step(); cm_fail = 1'b0;
        repeat (4095) step();
        chk("R5 check not yet passed", scm_active, 1'b1);
        step();
        chk("R6 scm off first", scm_active, 1'b0);
        chk("R6 pll still on", pll_en, 1'b1);
        chk("R6 vreg still on", vreg_en, 1'b1);
        step();
        chk("R6 pll off second", pll_en, 1'b0);
        chk("R6 vreg on at pll off", vreg_en, 1'b1);
        step();
        chk("R6 vreg off third", vreg_en, 1'b0);
        chk("R6 stays in stop", stop_exit, 1'b0);
        chk("R10 flag sticky", scm_flag, 1'b1);
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
        chk("R10 flag cleared", scm_flag, 1'b0);
        chk("R10 irq cleared", scm_irq, 1'b0);
        wakeup = 1'b1; step(); wakeup = 1'b0;
        chk("R7 exit strobe", stop_exit, 1'b1);
        chk("R7 osc selected", sysclk_pll, 1'b0);
        chk("R7 vreg on", vreg_en, 1'b1);
        step();
        chk("R7 strobe one cycle", stop_exit, 1'b0);

        // Wakeup during unrecovered failure (R8 R5)
        do_reset();
        enter_stop();
        cm_fail = 1'b1; step();
        repeat (5000) step();
        chk("R5 checks keep repeating", scm_active, 1'b1);
        wakeup = 1'b1; step(); wakeup = 1'b0;
        chk("R8 exit strobe", stop_exit, 1'b1);
        chk("R8 pll selected", sysclk_pll, 1'b1);
        chk("R8 pll on", pll_en, 1'b1);
        cm_fail = 1'b0;
        repeat (4095) step();
        chk("R8 still on pll", sysclk_pll, 1'b1);
        step();
        chk("R8 osc after pass", sysclk_pll, 1'b0);
        chk("R8 scm off after pass", scm_active, 1'b0);
        chk("R8 pll off after pass", pll_en, 1'b0);

        // External reset, unrecovered and recovered (R9)
        do_reset();
        enter_stop();
        cm_fail = 1'b1; step();
        ext_rst = 1'b1; step(); ext_rst = 1'b0;
        chk("R9 seq_reset unrecovered", seq_reset, 1'b1);
        chk("R9 exit unrecovered", stop_exit, 1'b1);
        chk("R9 pll source", sysclk_pll, 1'b1);
        step();
        chk("R9 seq_reset one cycle", seq_reset, 1'b0);
        cm_fail = 1'b0;
        do_reset();
        enter_stop();
        ext_rst = 1'b1; step(); ext_rst = 1'b0;
        chk("R9 seq_reset recovered", seq_reset, 1'b1);
        chk("R9 exit recovered", stop_exit, 1'b1);
        chk("R9 osc source", sysclk_pll, 1'b0);

        // Set and clear in the same cycle; interrupt gating (R10)
        cfg_irq_en = 1'b0;
        do_reset();
        enter_stop();
        cm_fail = 1'b1; flag_clr = 1'b1; step(); flag_clr = 1'b0;
        chk("R10 set beats clear", scm_flag, 1'b1);
        chk("R10 irq masked", scm_irq, 1'b0);
        cfg_irq_en = 1'b1; #1;
        chk("R10 irq unmasked", scm_irq, 1'b1);
        cm_fail = 1'b0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule